// File: doc/BRIEF.md
# 66-bit Block Stream Deframer

This block takes the 66-bit blocks of a single, already aligned and descrambled serial lane and rebuilds frames on an AXI4-Stream output. Each block carries a 2-bit header and eight payload bytes. A data block supplies eight frame bytes. A control block is classified by its type byte. Idle and clock-compensation blocks are removed, and so is any other control type that is not recognised. A separator block ends the current frame. Its count byte gives how many of its trailing bytes belong to the frame.

The most recent data block is always held back in a one-beat register. When the next data block arrives, the held block goes out as a full mid-frame beat. When a separator arrives, the held block either becomes the closing beat itself (count zero) or goes out just before a short closing beat made from the separator bytes. The block has no notion of being inside or outside a frame, so data that follows a closed frame simply opens the next one. The input side has a ready signal, so backpressure on the output stalls the lane feed instead of losing blocks. Two error indications are provided: a one-cycle pulse for an oversized separator count, and a saturating count of blocks whose header is illegal.

Top module: `s66_rx_deframer`

## Requirements
- R1: A block with header 2'b01 is data. Its eight bytes are emitted as one beat with m_tkeep = 8'hFF and m_tlast = 0, with block bits [7:0] on output byte 0.
- R2: A control block (header 2'b10) whose type byte blk_data[7:0] is idle (8'h78), clock compensation (8'h4B) or any value other than 8'h1E produces no output beat.
- R3: A control block with type byte 8'h1E is a separator with count c in blk_data[15:8]. For 1 ≤ c ≤ 6 it produces a closing beat with m_tlast = 1 and m_tkeep having its low c bits set, and block bytes 2..c+1 appear on output bytes 0..c-1.
- R4: A data block is not emitted until the next data or separator block has been accepted. Data blocks leave in their arrival order.
- R5: A separator with c = 0 sets m_tlast on the held data beat and adds no beat. If no data beat is held, it produces one beat with m_tkeep = 0 and m_tlast = 1.
- R6: A separator with c > 6 is handled as c = 6, and proto_err pulses high for exactly one cycle, one cycle after that block is accepted.
- R7: Blocks with header 2'b00 or 2'b11 produce no output and increment bad_hdr_cnt by one, which saturates at all ones.
- R8: While m_tvalid is high and m_tready is low, m_tdata, m_tkeep and m_tlast hold their values. A block is taken only in a cycle where blk_valid and blk_ready are both high.
- R9: Data accepted after a closing beat, or with no earlier separator, opens a new frame with no lost bytes.
- R10: After reset, m_tvalid = 0, proto_err = 0, bad_hdr_cnt = 0 and blk_ready = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| blk_valid | input | 1 | A block is presented |
| blk_hdr | input | 2 | Block header |
| blk_data | input | 64 | Block payload, byte 0 in bits [7:0] |
| blk_ready | output | 1 | The block is taken in this cycle if blk_valid is high |
| m_tvalid | output | 1 | Output beat valid |
| m_tready | input | 1 | Downstream accepts the beat |
| m_tdata | output | 64 | Output beat bytes |
| m_tkeep | output | 8 | Valid byte lanes, packed from bit 0 |
| m_tlast | output | 1 | Final beat of a frame |
| proto_err | output | 1 | One-cycle pulse when a separator count exceeds 6 |
| bad_hdr_cnt | output | 8 | Saturating count of illegal-header blocks |

## Verification
The bench checks the case where a separator arrives with a data beat held and with no beat held. A design that emitted data at once, or that ignored the held register, would show a missing tlast, a doubled beat or reordered beats. It also sends count zero, which must move tlast onto the held beat or produce an empty closing beat, and oversized counts, which must be clamped and flagged and never expose more than six bytes. Idle, clock-compensation, unknown-control and illegal-header blocks are interleaved inside frames, so a design that let any of them through would put extra beats in the scoreboard. Output backpressure is applied at random, so a design that changed a beat while stalled, or took a block it could not place, would drop or corrupt bytes.

// File: rtl/dfr_pkg.sv
package dfr_pkg;
  localparam int BLK_BYTES = 8;
  localparam int BLK_W     = BLK_BYTES * 8;
  localparam int SEP_MAX   = BLK_BYTES - 2;
  localparam int CNT_W     = $clog2(BLK_BYTES);

  localparam logic [1:0] HDR_DATA = 2'b01;
  localparam logic [1:0] HDR_CTRL = 2'b10;

  localparam logic [7:0] TYPE_SEP  = 8'h1E;
  localparam logic [7:0] TYPE_IDLE = 8'h78;
  localparam logic [7:0] TYPE_CC   = 8'h4B;

  typedef enum logic [1:0] {K_DATA, K_SEP, K_DROP, K_BAD} blk_kind_e;

  // Contiguous byte-enable mask with the low n lanes set
  function automatic logic [BLK_BYTES-1:0] keep_of(input logic [CNT_W-1:0] n);
    logic [BLK_BYTES-1:0] m;
    for (int i = 0; i < BLK_BYTES; i++) m[i] = (i < int'(n));
    return m;
  endfunction

  // Limit a raw separator count to the payload room of the block
  function automatic logic [CNT_W-1:0] clamp_cnt(input logic [7:0] raw);
    if (raw > 8'(SEP_MAX)) return CNT_W'(SEP_MAX);
    return raw[CNT_W-1:0];
  endfunction

  // Separator payload begins after the type and count bytes
  function automatic logic [BLK_W-1:0] sep_payload(input logic [BLK_W-1:0] d);
    return d >> 16;
  endfunction
endpackage

// File: rtl/dfr_classify.sv
module dfr_classify
  import dfr_pkg::*;
(
  input  logic [1:0]       hdr,
  input  logic [15:0]      head,
  output blk_kind_e        kind,
  output logic [CNT_W-1:0] cnt,
  output logic             over
);
  logic [7:0] type_b;
  logic [7:0] raw_cnt;
  logic       is_idle;
  logic       is_cc;

  assign type_b  = head[7:0];
  assign raw_cnt = head[15:8];
  assign is_idle = (type_b == TYPE_IDLE);
  assign is_cc   = (type_b == TYPE_CC);
  assign cnt     = clamp_cnt(raw_cnt);

  always_comb begin
    over = 1'b0;
    unique case (hdr)
      HDR_DATA: kind = K_DATA;
      HDR_CTRL: begin
        if (type_b == TYPE_SEP) begin
          kind = K_SEP;
          over = (raw_cnt > 8'(SEP_MAX));
        end else begin
          // idle, clock compensation and unknown types are all dropped
          kind = K_DROP;
        end
      end
      default: kind = K_BAD;
    endcase
  end

  // R2
  ctrl_drop_chk: assert final (!((hdr == HDR_CTRL) && (is_idle || is_cc)) || (kind == K_DROP));
endmodule

// File: rtl/dfr_err_count.sv
module dfr_err_count #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  logic at_max;
  assign at_max = (cnt == {W{1'b1}});

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt <= '0;
    else if (inc && !at_max) cnt <= cnt + 1'b1;
  end

  // R7
  bad_cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inc && !at_max |=> cnt == $past(cnt) + 1'b1);
  // R7
  bad_cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inc |=> $stable(cnt));
endmodule

// File: rtl/dfr_beat_path.sv
module dfr_beat_path
  import dfr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  blk_kind_e            in_kind,
  input  logic [BLK_W-1:0]     in_data,
  input  logic [CNT_W-1:0]     in_cnt,
  output logic                 in_ready,
  output logic                 in_take,
  input  logic                 m_tready,
  output logic                 o_valid,
  output logic [BLK_W-1:0]     o_data,
  output logic [BLK_BYTES-1:0] o_keep,
  output logic                 o_last
);
  // held beat
  logic                 h_v;
  logic                 h_last;
  logic [BLK_W-1:0]     h_data;
  logic [BLK_BYTES-1:0] h_keep;

  // named events
  logic out_free;
  logic last_pending;
  logic take_data;
  logic take_sep;
  logic drain;
  logic push;
  logic [BLK_W-1:0]     p_data;
  logic [BLK_BYTES-1:0] p_keep;
  logic                 p_last;

  assign out_free     = !o_valid || m_tready;
  assign last_pending = h_v && h_last;
  assign in_ready     = out_free && !last_pending;
  assign in_take      = in_valid && in_ready;
  assign take_data    = in_take && (in_kind == K_DATA);
  assign take_sep     = in_take && (in_kind == K_SEP);
  assign drain        = last_pending && out_free;

  always_comb begin
    push   = 1'b0;
    p_data = h_data;
    p_keep = h_keep;
    p_last = h_last;
    if (drain) begin
      push = 1'b1;
    end else if (take_data && h_v) begin
      push   = 1'b1;
      p_last = 1'b0;
    end else if (take_sep) begin
      push = 1'b1;
      if (h_v) begin
        p_last = (in_cnt == '0);
      end else begin
        p_data = sep_payload(in_data);
        p_keep = keep_of(in_cnt);
        p_last = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      o_valid <= 1'b0;
      o_data  <= '0;
      o_keep  <= '0;
      o_last  <= 1'b0;
    end else if (push) begin
      o_valid <= 1'b1;
      o_data  <= p_data;
      o_keep  <= p_keep;
      o_last  <= p_last;
    end else if (o_valid && m_tready) begin
      o_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h_v    <= 1'b0;
      h_last <= 1'b0;
      h_data <= '0;
      h_keep <= '0;
    end else if (drain) begin
      h_v <= 1'b0;
    end else if (take_data) begin
      h_v    <= 1'b1;
      h_last <= 1'b0;
      h_data <= in_data;
      h_keep <= '1;
    end else if (take_sep && h_v) begin
      if (in_cnt != '0) begin
        h_last <= 1'b1;
        h_data <= sep_payload(in_data);
        h_keep <= keep_of(in_cnt);
      end else begin
        h_v <= 1'b0;
      end
    end
  end

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid && !m_tready |=> o_valid && $stable(o_data) && $stable(o_keep) && $stable(o_last));
  // R1
  full_mid_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid && !o_last |-> o_keep == '1);
  // R3
  keep_contig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid |-> (o_keep & (o_keep + BLK_BYTES'(1))) == '0);
  // R4
  data_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_data |=> h_v && !h_last);
endmodule

// File: rtl/s66_rx_deframer.sv
module s66_rx_deframer
  import dfr_pkg::*;
#(
  parameter int ERR_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 blk_valid,
  input  logic [1:0]           blk_hdr,
  input  logic [BLK_W-1:0]     blk_data,
  output logic                 blk_ready,
  output logic                 m_tvalid,
  input  logic                 m_tready,
  output logic [BLK_W-1:0]     m_tdata,
  output logic [BLK_BYTES-1:0] m_tkeep,
  output logic                 m_tlast,
  output logic                 proto_err,
  output logic [ERR_W-1:0]     bad_hdr_cnt
);
  blk_kind_e        kind;
  logic [CNT_W-1:0] cnt;
  logic             over;
  logic             take;
  logic             sep_over_take;
  logic             bad_take;

  dfr_classify u_cls (
    .hdr  (blk_hdr),
    .head (blk_data[15:0]),
    .kind (kind),
    .cnt  (cnt),
    .over (over)
  );

  dfr_beat_path u_path (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (blk_valid),
    .in_kind  (kind),
    .in_data  (blk_data),
    .in_cnt   (cnt),
    .in_ready (blk_ready),
    .in_take  (take),
    .m_tready (m_tready),
    .o_valid  (m_tvalid),
    .o_data   (m_tdata),
    .o_keep   (m_tkeep),
    .o_last   (m_tlast)
  );

  assign sep_over_take = take && (kind == K_SEP) && over;
  assign bad_take      = take && (kind == K_BAD);

  always_ff @(posedge clk) begin
    if (!rst_n) proto_err <= 1'b0;
    else        proto_err <= sep_over_take;
  end

  dfr_err_count #(.W(ERR_W)) u_bad (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (bad_take),
    .cnt   (bad_hdr_cnt)
  );

  // R6
  proto_err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> $past(sep_over_take));
  // R6
  proto_err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sep_over_take |=> proto_err);
endmodule

// File: tb/s66_rx_deframer_tb_top.sv
module s66_rx_deframer_tb_top;
  typedef struct packed {
    logic        last;
    logic [7:0]  keep;
    logic [63:0] data;
  } beat_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        blk_valid = 1'b0;
  logic [1:0]  blk_hdr = 2'b00;
  logic [63:0] blk_data = '0;
  logic        blk_ready;
  logic        m_tvalid;
  logic        m_tready = 1'b1;
  logic [63:0] m_tdata;
  logic [7:0]  m_tkeep;
  logic        m_tlast;
  logic        proto_err;
  logic [7:0]  bad_hdr_cnt;

  int checks = 0;
  int errors = 0;
  bit bp = 1'b0;
  bit done = 1'b0;

  beat_t exp_q[$];
  string tag_q[$];
  logic        mh_v = 1'b0;
  logic [63:0] mh_d = '0;
  int exp_perr = 0;
  int got_perr = 0;
  int exp_bad = 0;
  logic [63:0] seq = 64'h1000;

  s66_rx_deframer dut_i (
    .clk(clk), .rst_n(rst_n), .blk_valid(blk_valid), .blk_hdr(blk_hdr),
    .blk_data(blk_data), .blk_ready(blk_ready), .m_tvalid(m_tvalid),
    .m_tready(m_tready), .m_tdata(m_tdata), .m_tkeep(m_tkeep),
    .m_tlast(m_tlast), .proto_err(proto_err), .bad_hdr_cnt(bad_hdr_cnt)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    #1;
    m_tready = bp ? ($urandom_range(0, 3) != 0) : 1'b1;
  end

  function automatic logic [7:0] lanes(input int n);
    logic [7:0] m = '0;
    for (int b = 0; b < 8; b++) if (b < n) m[b] = 1'b1;
    return m;
  endfunction

  function automatic logic [63:0] bytemask(input logic [7:0] k);
    logic [63:0] m;
    for (int b = 0; b < 8; b++) m[b*8 +: 8] = {8{k[b]}};
    return m;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic expect_beat(input logic [63:0] d, input logic [7:0] k, input logic l,
                             input string tag);
    beat_t b;
    b.data = d; b.keep = k; b.last = l;
    exp_q.push_back(b);
    tag_q.push_back(tag);
  endtask

  // reference model, written from the requirements
  task automatic model(input logic [1:0] h, input logic [63:0] d);
    int c;
    if (h == 2'b01) begin
      if (mh_v) expect_beat(mh_d, 8'hFF, 1'b0, "R1/R4 mid beat");
      mh_v = 1'b1;
      mh_d = d;
    end else if (h == 2'b10) begin
      if (d[7:0] == 8'h1E) begin
        c = int'(d[15:8]);
        if (c > 6) begin c = 6; exp_perr++; end
        if (mh_v && c == 0) begin
          expect_beat(mh_d, 8'hFF, 1'b1, "R5 tlast on held beat");
        end else begin
          if (mh_v) expect_beat(mh_d, 8'hFF, 1'b0, "R4 beat before closing");
          expect_beat(d >> 16, lanes(c), 1'b1, c == 0 ? "R5 empty close" : "R3/R6 closing beat");
        end
        mh_v = 1'b0;
      end
    end else begin
      if (exp_bad < 255) exp_bad++;
    end
  endtask

  task automatic send(input logic [1:0] h, input logic [63:0] d);
    @(negedge clk);
    blk_valid = 1'b1; blk_hdr = h; blk_data = d;
    while (!blk_ready) @(negedge clk);
    model(h, d);
    @(posedge clk);
    #1 blk_valid = 1'b0;
  endtask

  task automatic data_blk();
    seq = seq + 64'h0101_0101_0101_0101;
    send(2'b01, seq);
  endtask

  task automatic sep_blk(input logic [7:0] c);
    seq = seq + 64'h0303_0303_0303_0303;
    send(2'b10, {seq[63:16], c, 8'h1E});
  endtask

  task automatic idle_blk(input logic [7:0] t);
    send(2'b10, {seq[63:8], t});
  endtask

  // scoreboard monitor and stall check
  bit    stall_prev = 1'b0;
  beat_t prev_b;
  always @(negedge clk) begin
    beat_t cur, e;
    string t;
    cur.data = m_tdata; cur.keep = m_tkeep; cur.last = m_tlast;
    if (rst_n) begin
      if (proto_err) got_perr++;
      if (stall_prev)
        check(m_tvalid && cur == prev_b, "R8", "stalled beat changed",
              {7'b0, m_tvalid, cur}, {8'h1, prev_b});
      if (m_tvalid && m_tready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2", "unexpected beat", {7'b0, cur}, '0);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(cur.keep == e.keep && cur.last == e.last &&
                (cur.data & bytemask(e.keep)) == (e.data & bytemask(e.keep)),
                t, "beat", {7'b0, cur.last, cur.keep, cur.data & bytemask(e.keep)},
                {7'b0, e.last, e.keep, e.data & bytemask(e.keep)});
        end
      end
      stall_prev = m_tvalid && !m_tready;
      prev_b = cur;
    end
  end

  task automatic settle();
    for (int i = 0; i < 200 && exp_q.size() != 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10
    check(!m_tvalid && !proto_err && bad_hdr_cnt == 0 && blk_ready, "R10", "reset state",
          {m_tvalid, proto_err, bad_hdr_cnt, blk_ready}, 11'b00_00000000_1);

    // R1 R3: plain frame
    data_blk(); data_blk(); data_blk(); sep_blk(8'd4);
    settle();

    // R4: a lone data block stays held
    data_blk();
    repeat (4) @(negedge clk);
    check(!m_tvalid, "R4", "held data leaked", m_tvalid, 0);
    sep_blk(8'd6);

    // R2: idles, clock compensation and unknown control inside a frame
    data_blk(); idle_blk(8'h78); data_blk(); idle_blk(8'h4B); idle_blk(8'h33);
    data_blk(); idle_blk(8'h78); sep_blk(8'd2);
    settle();

    // R5: count zero with and without a held beat
    data_blk(); data_blk(); sep_blk(8'd0);
    sep_blk(8'd0);

    // R6: oversized counts
    data_blk(); sep_blk(8'd9);
    sep_blk(8'd255);

    // R7: illegal headers inside a frame
    data_blk(); send(2'b00, 64'hDEAD); send(2'b11, 64'hBEEF); data_blk(); sep_blk(8'd1);

    // R9: separator with no data, then data opening a new frame
    sep_blk(8'd3); data_blk(); data_blk(); sep_blk(8'd5);
    settle();

    // R8: random backpressure
    bp = 1'b1;
    for (int f = 0; f < 40; f++) begin
      for (int k = 0; k < (f % 4); k++) data_blk();
      if (f % 3 == 0) idle_blk(8'h78);
      sep_blk(8'(f % 8));
    end
    settle();
    bp = 1'b0;

    // R7: saturation
    for (int i = 0; i < 260; i++) send(2'b11, 64'h0);
    settle();

    check(exp_q.size() == 0, "R4", "beats missing", exp_q.size(), 0);
    check(int'(bad_hdr_cnt) == exp_bad, "R7", "bad header count", bad_hdr_cnt, exp_bad);
    check(got_perr == exp_perr, "R6", "proto_err pulses", got_perr, exp_perr);
    finish_run();
  end
endmodule